// File: doc/BRIEF.md
# Register-Loaded Translation Buffer

A small fully associative address translation buffer whose contents change only through control-register writes. Software loads an entry in two steps: one write stages half of the entry and a second write, to a different register, commits it. The data flavour stages the page-table word first, and the tag write commits it. The instruction flavour stages the tag first, and the page-table write commits it. A parameter picks the flavour. Each entry holds a virtual page tag, a physical page number, four read enables, four write enables, fault-on-read and fault-on-write bits, a global (match-any-space) flag and the address-space ID that was current at fill time.

Three invalidate writes remove entries: all of them, every non-global entry, or the one entry that would hit for a given address under the current space ID. A lookup port translates a virtual page combinationally. A read-back port returns any slot as one packed 64-bit word. A fill whose page-table word carries a nonzero granularity-hint field is refused and flagged.

Top module: `regfill_tlb`

## Requirements
- R1: After reset no slot is valid, every read-back word is zero, lookups miss and the victim slot is 0.
- R2: Data flavour (IS_INSTR=0): a write with select 0 stages the page-table word; a later write with select 1 fills the victim slot with tag wr_data[42:13], the staged word and the current space ID.
- R3: Instruction flavour (IS_INSTR=1): select 1 stages the tag from wr_data[42:13]; a select 0 write fills the victim slot from its own data and the staged tag, with the write enables forced to zero.
- R4: A fill whose page-table word has a nonzero hint field wr_data[6:5] raises fill_err during that write, changes no slot and does not advance the victim slot.
- R5: Page-table word and packed read-back share one layout: page number [58:32], read enables [11:8], write enables [15:12], fault-on-read [1], fault-on-write [2], global [4]; read-back also ORs the 7-bit space ID into [63:57].
- R6: A lookup hits when a valid slot's tag equals lk_vpn and its space ID equals the current one or its global flag is set; lk_ppn then gives that slot's page number.
- R7: A write with select 3 invalidates every slot.
- R8: A write with select 4 invalidates every slot whose global flag is clear and keeps global slots.
- R9: A write with select 5 invalidates the slot that a lookup of wr_data[42:13] under the current space ID would hit.
- R10: Fills go to slots in round-robin order 0,1,...,N_ENT-1,0, overwriting whatever is there.
- R11: A write with select 2 sets the current space ID from wr_data[63:57]; staging writes alone change no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (0 page word, 1 tag, 2 space ID, 3 flush all, 4 flush non-global, 5 flush one) |
| wr_data | input | 64 | Write data |
| lk_vpn | input | VPN_W | Virtual page to translate |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | 27 | Physical page of the hit slot |
| rd_idx | input | IDX_W | Slot to read back |
| rd_valid | output | 1 | Read-back slot is valid |
| rd_data | output | 64 | Packed read-back word |
| fill_err | output | 1 | Fill refused due to a nonzero hint field |

## Verification
On every cycle the assertions check that a refused fill leaves the valid set and the victim slot untouched, that a fill marks the victim slot valid and advances it by one with wrap, that flush-all leaves nothing valid, and that the instruction flavour never shows write enables. The bench scenarios alone can show the hit rule across space IDs and the global flag, which slots the selective invalidates spare, the exact packed layout including the overlapping bits, and the difference between the two fill orders.

// File: rtl/regfill_tlb_pkg.sv
package regfill_tlb_pkg;

  localparam int PPN_W   = 27;
  localparam int PERM_W  = 4;
  localparam int SPACE_W = 7;
  localparam int PG_SHIFT = 13;

  typedef enum logic [2:0] {
    SEL_PTE        = 3'd0,
    SEL_TAG        = 3'd1,
    SEL_SPACE      = 3'd2,
    SEL_FLUSH_ALL  = 3'd3,
    SEL_FLUSH_PROC = 3'd4,
    SEL_FLUSH_ONE  = 3'd5
  } wsel_e;

  typedef struct packed {
    logic [PPN_W-1:0]   ppn;
    logic [PERM_W-1:0]  rd_en;
    logic [PERM_W-1:0]  wr_en;
    logic               f_rd;
    logic               f_wr;
    logic               glob;
    logic [SPACE_W-1:0] space;
  } pte_t;

  // Page-table word to entry fields; space comes from the current register.
  function automatic pte_t unpack_pte(input logic [63:0] w,
                                      input logic [SPACE_W-1:0] sp,
                                      input logic force_ro);
    pte_t p;
    p.ppn   = w[58:32];
    p.rd_en = w[11:8];
    p.wr_en = force_ro ? '0 : w[15:12];
    p.f_rd  = w[1];
    p.f_wr  = w[2];
    p.glob  = w[4];
    p.space = sp;
    return p;
  endfunction

  function automatic logic [1:0] hint_of(input logic [63:0] w);
    return w[6:5];
  endfunction

  // Packed read-back: space ID shares bits 57/58 with the page number (OR).
  function automatic logic [63:0] pack_pte(input pte_t p);
    logic [63:0] r;
    r = '0;
    r[58:32] = p.ppn;
    r[11:8]  = p.rd_en;
    r[15:12] = p.wr_en;
    r[1]     = p.f_rd;
    r[2]     = p.f_wr;
    r[4]     = p.glob;
    r[63:57] = r[63:57] | p.space;
    return r;
  endfunction

endpackage

// File: rtl/tlbr_decode.sv
module tlbr_decode
  import regfill_tlb_pkg::*;
#(
  parameter int VPN_W    = 30,
  parameter bit IS_INSTR = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [2:0]         wr_sel,
  input  logic [63:0]        wr_data,
  output logic               ins_fire,
  output logic               gh_block,
  output pte_t               ins_pte,
  output logic [VPN_W-1:0]   ins_vpn,
  output logic [SPACE_W-1:0] space_q,
  output logic               inv_all,
  output logic               inv_proc,
  output logic               inv_one,
  output logic [VPN_W-1:0]   inv_vpn
);

  logic [VPN_W-1:0] wr_vpn;
  logic             trigger;
  logic [63:0]      fill_word;

  assign wr_vpn = wr_data[PG_SHIFT +: VPN_W];

  always_ff @(posedge clk) begin
    if (!rst_n) space_q <= '0;
    else if (wr_en && wr_sel == SEL_SPACE) space_q <= wr_data[63:57];
  end

  generate
    if (IS_INSTR) begin : g_instr
      logic [VPN_W-1:0] staged_vpn;
      always_ff @(posedge clk) begin
        if (!rst_n) staged_vpn <= '0;
        else if (wr_en && wr_sel == SEL_TAG) staged_vpn <= wr_vpn;
      end
      assign trigger   = wr_en && (wr_sel == SEL_PTE);
      assign fill_word = wr_data;
      assign ins_vpn   = staged_vpn;
    end else begin : g_data
      logic [63:0] staged_word;
      always_ff @(posedge clk) begin
        if (!rst_n) staged_word <= '0;
        else if (wr_en && wr_sel == SEL_PTE) staged_word <= wr_data;
      end
      assign trigger   = wr_en && (wr_sel == SEL_TAG);
      assign fill_word = staged_word;
      assign ins_vpn   = wr_vpn;
    end
  endgenerate

  assign gh_block = trigger && (hint_of(fill_word) != 2'b00);
  assign ins_fire = trigger && !gh_block;
  assign ins_pte  = unpack_pte(fill_word, space_q, IS_INSTR);

  assign inv_all  = wr_en && (wr_sel == SEL_FLUSH_ALL);
  assign inv_proc = wr_en && (wr_sel == SEL_FLUSH_PROC);
  assign inv_one  = wr_en && (wr_sel == SEL_FLUSH_ONE);
  assign inv_vpn  = wr_vpn;

endmodule

// File: rtl/tlbr_victim.sv
module tlbr_victim #(
  parameter int N_ENT = 8,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENT - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)   ptr <= '0;
    else if (adv) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

endmodule

// File: rtl/tlbr_array.sv
module tlbr_array
  import regfill_tlb_pkg::*;
#(
  parameter int N_ENT = 8,
  parameter int VPN_W = 30,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ins_fire,
  input  logic [IDX_W-1:0]   ins_slot,
  input  logic [VPN_W-1:0]   ins_vpn,
  input  pte_t               ins_pte,
  input  logic               inv_all,
  input  logic               inv_proc,
  input  logic               inv_one,
  input  logic [VPN_W-1:0]   inv_vpn,
  input  logic [SPACE_W-1:0] cur_space,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic               lk_hit,
  output logic [PPN_W-1:0]   lk_ppn,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic               rd_valid,
  output pte_t               rd_pte,
  output logic [N_ENT-1:0]   valid_vec
);

  logic [VPN_W-1:0] ent_tag [N_ENT];
  pte_t             ent_pte [N_ENT];

  function automatic logic slot_match(input logic v, input logic [VPN_W-1:0] tag,
                                      input pte_t p, input logic [VPN_W-1:0] vpn,
                                      input logic [SPACE_W-1:0] sp);
    return v && (tag == vpn) && (p.glob || (p.space == sp));
  endfunction

  for (genvar g = 0; g < N_ENT; g++) begin : g_slot
    logic             v_q;
    logic [VPN_W-1:0] tag_q;
    pte_t             pte_q;
    logic             kill;

    assign kill = inv_all || (inv_proc && !pte_q.glob) ||
                  (inv_one && slot_match(v_q, tag_q, pte_q, inv_vpn, cur_space));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q   <= 1'b0;
        tag_q <= '0;
        pte_q <= '0;
      end else if (ins_fire && ins_slot == IDX_W'(g)) begin
        v_q   <= 1'b1;
        tag_q <= ins_vpn;
        pte_q <= ins_pte;
      end else if (kill) begin
        v_q   <= 1'b0;
      end
    end

    assign valid_vec[g] = v_q;
    assign ent_tag[g]   = tag_q;
    assign ent_pte[g]   = pte_q;
  end

  always_comb begin
    lk_hit = 1'b0;
    lk_ppn = '0;
    for (int k = N_ENT - 1; k >= 0; k--) begin
      if (slot_match(valid_vec[k], ent_tag[k], ent_pte[k], lk_vpn, cur_space)) begin
        lk_hit = 1'b1;
        lk_ppn = ent_pte[k].ppn;
      end
    end
  end

  assign rd_valid = valid_vec[rd_idx];
  assign rd_pte   = ent_pte[rd_idx];

endmodule

// File: rtl/regfill_tlb.sv
module regfill_tlb
  import regfill_tlb_pkg::*;
#(
  parameter int N_ENT    = 8,
  parameter int VPN_W    = 30,
  parameter bit IS_INSTR = 1'b0,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [63:0]      wr_data,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [26:0]      lk_ppn,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [63:0]      rd_data,
  output logic             fill_err
);

  logic               ins_fire;
  logic               gh_block;
  pte_t               ins_pte;
  logic [VPN_W-1:0]   ins_vpn;
  logic [SPACE_W-1:0] space_q;
  logic               inv_all, inv_proc, inv_one;
  logic [VPN_W-1:0]   inv_vpn;
  logic [IDX_W-1:0]   vic_ptr;
  logic [N_ENT-1:0]   valid_vec;
  pte_t               rd_pte;

  tlbr_decode #(.VPN_W(VPN_W), .IS_INSTR(IS_INSTR)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ins_fire(ins_fire), .gh_block(gh_block), .ins_pte(ins_pte), .ins_vpn(ins_vpn),
    .space_q(space_q), .inv_all(inv_all), .inv_proc(inv_proc), .inv_one(inv_one),
    .inv_vpn(inv_vpn)
  );

  tlbr_victim #(.N_ENT(N_ENT)) u_vic (
    .clk(clk), .rst_n(rst_n), .adv(ins_fire), .ptr(vic_ptr)
  );

  tlbr_array #(.N_ENT(N_ENT), .VPN_W(VPN_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .ins_fire(ins_fire), .ins_slot(vic_ptr),
    .ins_vpn(ins_vpn), .ins_pte(ins_pte), .inv_all(inv_all), .inv_proc(inv_proc),
    .inv_one(inv_one), .inv_vpn(inv_vpn), .cur_space(space_q), .lk_vpn(lk_vpn),
    .lk_hit(lk_hit), .lk_ppn(lk_ppn), .rd_idx(rd_idx), .rd_valid(rd_valid),
    .rd_pte(rd_pte), .valid_vec(valid_vec)
  );

  assign rd_data  = pack_pte(rd_pte);
  assign fill_err = gh_block;

endmodule

// File: rtl/regfill_tlb_chk.sv
module regfill_tlb_chk
  import regfill_tlb_pkg::*;
#(
  parameter int N_ENT    = 8,
  parameter bit IS_INSTR = 1'b0,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [2:0]       wr_sel,
  input logic             ins_fire,
  input logic             gh_block,
  input logic [IDX_W-1:0] vic_ptr,
  input logic [N_ENT-1:0] valid_vec,
  input logic             lk_hit,
  input logic [63:0]      rd_data
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENT - 1);

  // R1
  a_r1_reset_empty: assert property (@(posedge clk)
    !rst_n |=> (valid_vec == '0) && (vic_ptr == '0));

  // R4
  a_r4_refused_fill_inert: assert property (@(posedge clk) disable iff (!rst_n)
    gh_block |=> (valid_vec == $past(valid_vec)) && (vic_ptr == $past(vic_ptr)));

  // R2 / R3
  a_r2_fill_marks_valid: assert property (@(posedge clk) disable iff (!rst_n)
    ins_fire |=> valid_vec[$past(vic_ptr)]);

  // R10
  a_r10_round_robin: assert property (@(posedge clk) disable iff (!rst_n)
    ins_fire |=> vic_ptr == (($past(vic_ptr) == LAST) ? '0 : $past(vic_ptr) + 1'b1));

  a_r10_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_fire |=> $stable(vic_ptr));

  // R7
  a_r7_flush_all_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_FLUSH_ALL) |=> (valid_vec == '0) && !lk_hit);

  // R6
  a_r6_hit_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (valid_vec != '0));

  // R3
  if (IS_INSTR) begin : g_ro
    a_r3_no_write_enable: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[15:12] == 4'h0);
  end

endmodule

bind regfill_tlb regfill_tlb_chk #(.N_ENT(N_ENT), .IS_INSTR(IS_INSTR)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .ins_fire(ins_fire),
  .gh_block(gh_block), .vic_ptr(vic_ptr), .valid_vec(valid_vec), .lk_hit(lk_hit),
  .rd_data(rd_data)
);

// File: tb/regfill_tlb_tb.sv
`timescale 1ns/1ps
module regfill_tlb_tb;

  localparam int VW = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  // data flavour stimulus
  logic          d_wr_en = 1'b0;
  logic [2:0]    d_sel = '0;
  logic [63:0]   d_data = '0;
  logic [VW-1:0] d_lk = '0;
  logic [2:0]    d_idx = '0;
  logic          d_hit, d_rv, d_err;
  logic [26:0]   d_ppn;
  logic [63:0]   d_rd;

  // instruction flavour stimulus
  logic          i_wr_en = 1'b0;
  logic [2:0]    i_sel = '0;
  logic [63:0]   i_data = '0;
  logic [VW-1:0] i_lk = '0;
  logic [2:0]    i_idx = '0;
  logic          i_hit, i_rv, i_err;
  logic [26:0]   i_ppn;
  logic [63:0]   i_rd;

  regfill_tlb #(.N_ENT(8), .VPN_W(VW), .IS_INSTR(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(d_wr_en), .wr_sel(d_sel), .wr_data(d_data),
    .lk_vpn(d_lk), .lk_hit(d_hit), .lk_ppn(d_ppn), .rd_idx(d_idx),
    .rd_valid(d_rv), .rd_data(d_rd), .fill_err(d_err));

  regfill_tlb #(.N_ENT(8), .VPN_W(VW), .IS_INSTR(1'b1)) u_dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(i_wr_en), .wr_sel(i_sel), .wr_data(i_data),
    .lk_vpn(i_lk), .lk_hit(i_hit), .lk_ppn(i_ppn), .rd_idx(i_idx),
    .rd_valid(i_rv), .rd_data(i_rd), .fill_err(i_err));

  int n_chk = 0;
  int n_bad = 0;
  logic last_err;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Page-table word builder (hint field in bits 6:5)
  function automatic logic [63:0] pw(input logic [26:0] ppn, input logic [3:0] re,
      input logic [3:0] we, input logic fr, input logic fw, input logic g, input logic [1:0] gh);
    return ({37'd0, ppn} << 32) | (64'(we) << 12) | (64'(re) << 8) |
           (64'(gh) << 5) | (64'(g) << 4) | (64'(fw) << 2) | (64'(fr) << 1);
  endfunction

  function automatic logic [63:0] expect_rb(input logic [26:0] ppn, input logic [3:0] re,
      input logic [3:0] we, input logic fr, input logic fw, input logic g, input logic [6:0] sp);
    return pw(ppn, re, we, fr, fw, g, 2'b00) | ({57'd0, sp} << 57);
  endfunction

  function automatic logic [63:0] va(input logic [VW-1:0] v);
    return 64'(v) << 13;
  endfunction

  task automatic dwr(input logic [2:0] s, input logic [63:0] w);
    @(negedge clk);
    d_wr_en = 1'b1; d_sel = s; d_data = w;
    #1 last_err = d_err;
    @(negedge clk);
    d_wr_en = 1'b0;
  endtask

  task automatic iwr(input logic [2:0] s, input logic [63:0] w);
    @(negedge clk);
    i_wr_en = 1'b1; i_sel = s; i_data = w;
    #1 last_err = i_err;
    @(negedge clk);
    i_wr_en = 1'b0;
  endtask

  task automatic dlook(input logic [VW-1:0] v);
    d_lk = v; #0.5;
  endtask

  task automatic dpeek(input int i);
    d_idx = 3'(i); #0.5;
  endtask

  task automatic dspace(input logic [6:0] s);
    dwr(3'd2, {s, 57'd0});
  endtask

  task automatic dfill(input logic [63:0] w, input logic [VW-1:0] v);
    dwr(3'd0, w);
    dwr(3'd1, va(v));
  endtask

  task automatic t_reset;
    dpeek(0);
    check("R1 rd_valid", 64'(d_rv), 0);
    check("R1 rd_data", d_rd, 0);
    dlook(30'h1000);
    check("R1 lk_hit", 64'(d_hit), 0);
    check("R1 fill_err", 64'(d_err), 0);
  endtask

  task automatic t_data_fill;
    dspace(7'd5);
    dwr(3'd0, pw(27'h6000001, 4'hA, 4'h5, 1'b1, 1'b0, 1'b0, 2'b00));
    dpeek(0);
    check("R11 staging alone no fill", 64'(d_rv), 0);
    dwr(3'd1, va(30'h1000));
    dpeek(0);
    check("R2 slot0 valid", 64'(d_rv), 1);
    check("R5 packed overlap", d_rd, expect_rb(27'h6000001, 4'hA, 4'h5, 1'b1, 1'b0, 1'b0, 7'd5));
    dlook(30'h1000);
    check("R2 hit", 64'(d_hit), 1);
    check("R6 ppn", 64'(d_ppn), 64'h6000001);
  endtask

  task automatic t_hit_rule;
    dspace(7'd6);
    dlook(30'h1000);
    check("R6 other space misses", 64'(d_hit), 0);
    dfill(pw(27'h0000ABC, 4'h1, 4'h2, 1'b0, 1'b1, 1'b1, 2'b00), 30'h2000);
    dpeek(1);
    check("R5 global word", d_rd, expect_rb(27'h0000ABC, 4'h1, 4'h2, 1'b0, 1'b1, 1'b1, 7'd6));
    dspace(7'd7);
    dlook(30'h2000);
    check("R6 global hits any space", 64'(d_hit), 1);
    dspace(7'd5);
    dlook(30'h1000);
    check("R6 own space hits", 64'(d_hit), 1);
    dlook(30'h1001);
    check("R6 tag mismatch misses", 64'(d_hit), 0);
  endtask

  task automatic t_hint;
    dwr(3'd0, pw(27'h111, 4'h1, 4'h1, 1'b0, 1'b0, 1'b0, 2'b10));
    dwr(3'd1, va(30'h3000));
    check("R4 fill_err", 64'(last_err), 1);
    dpeek(2);
    check("R4 slot2 untouched", 64'(d_rv), 0);
    dfill(pw(27'h333, 4'h3, 4'h3, 1'b0, 1'b0, 1'b0, 2'b00), 30'h3000);
    check("R4 good fill no err", 64'(last_err), 0);
    dpeek(2);
    check("R4 ptr not advanced", 64'(d_rv), 1);
  endtask

  task automatic t_flush_one;
    dwr(3'd5, va(30'h2000));
    dpeek(1);
    check("R9 global match removed", 64'(d_rv), 0);
    dspace(7'd9);
    dwr(3'd5, va(30'h3000));
    dpeek(2);
    check("R9 other space kept", 64'(d_rv), 1);
    dspace(7'd5);
    dwr(3'd5, va(30'h3000));
    dpeek(2);
    check("R9 own space removed", 64'(d_rv), 0);
  endtask

  task automatic t_flush_proc;
    dfill(pw(27'h444, 4'h4, 4'h4, 1'b0, 1'b0, 1'b1, 2'b00), 30'h4000); // slot3
    dwr(3'd4, 64'd0);
    dpeek(0);
    check("R8 private cleared", 64'(d_rv), 0);
    dpeek(3);
    check("R8 global kept", 64'(d_rv), 1);
    dlook(30'h4000);
    check("R8 global still hits", 64'(d_hit), 1);
  endtask

  task automatic t_flush_all;
    dwr(3'd3, 64'd0);
    dpeek(3);
    check("R7 slot3 cleared", 64'(d_rv), 0);
    dlook(30'h4000);
    check("R7 no hit", 64'(d_hit), 0);
  endtask

  task automatic t_round_robin;
    for (int k = 0; k < 5; k++)
      dfill(pw(27'(16'h500 + k), 4'h1, 4'h0, 1'b0, 1'b0, 1'b0, 2'b00), 30'(16'h5000 + k));
    dpeek(4);
    check("R10 slot4", d_rd, expect_rb(27'h500, 4'h1, 4'h0, 1'b0, 1'b0, 1'b0, 7'd5));
    dpeek(7);
    check("R10 slot7", d_rd, expect_rb(27'h503, 4'h1, 4'h0, 1'b0, 1'b0, 1'b0, 7'd5));
    dpeek(0);
    check("R10 wrap to slot0", d_rd, expect_rb(27'h504, 4'h1, 4'h0, 1'b0, 1'b0, 1'b0, 7'd5));
    dlook(30'h5004);
    check("R10 wrapped entry hits", 64'(d_ppn), 64'h504);
  endtask

  task automatic t_instr;
    iwr(3'd2, {7'd3, 57'd0});
    iwr(3'd1, va(30'h777));
    i_idx = 3'd0; #0.5;
    check("R3 tag stage no fill", 64'(i_rv), 0);
    iwr(3'd0, pw(27'h5ABCDEF, 4'h3, 4'hF, 1'b1, 1'b1, 1'b0, 2'b00));
    i_idx = 3'd0; #0.5;
    check("R3 filled", 64'(i_rv), 1);
    check("R3 write enables zero", i_rd, expect_rb(27'h5ABCDEF, 4'h3, 4'h0, 1'b1, 1'b1, 1'b0, 7'd3));
    i_lk = 30'h777; #0.5;
    check("R3 hit staged tag", 64'(i_hit), 1);
    iwr(3'd0, pw(27'h1, 4'h1, 4'h0, 1'b0, 1'b0, 1'b0, 2'b01));
    check("R4 instr fill_err", 64'(last_err), 1);
    i_idx = 3'd1; #0.5;
    check("R4 instr slot1 untouched", 64'(i_rv), 0);
  endtask

  logic done = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_data_fill;
    t_hit_rule;
    t_hint;
    t_flush_one;
    t_flush_proc;
    t_flush_all;
    t_round_robin;
    t_instr;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule